// File: doc/BRIEF.md
# Pulse Width and Period Capture Timer

This block measures an external waveform against the system clock. Once software arms it, it waits for the first leading edge of the input. At that edge an internal counter starts at one and advances once per clock. At the trailing edge the current count, halved, is stored as the pulse width. At the next leading edge the halved count is stored as the period, and the counter restarts at one. The same single count therefore yields both measurements. A polarity bit decides whether the leading edge is the rising or the falling transition.

A sticky interrupt latch is set either by width capture or by period capture, as a select bit chooses. A counter that reaches all ones without seeing a leading edge counts as an overflow. The overflow stops the timer, clears its run bit, and sets both a sticky overflow flag and the interrupt latch. Both flags clear only through a write-one-to-clear on the status register. The input passes through a two-flop synchronizer before edge detection.

The register port is a simple synchronous one. Writes take effect on the clock edge where `wr_en` is high. Reads are combinational from `rd_addr`. Register map:

- Address 0, control:
  - bit 0: run
  - bit 1: rising edge leads
  - bit 2: interrupt on period capture
  - bit 3: interrupt output enable
- Address 1, status:
  - bit 0: interrupt latch
  - bit 1: overflow
- Address 2: width.
- Address 3: period.

The controller has four states:
- OFF: the timer is stopped.
- ARM: the timer is enabled and waits for the first leading edge.
- MARK: the timer is between a leading edge and a trailing edge.
- SPACE: the timer is between a trailing edge and the next leading edge.

Its transitions:
- start (OFF→ARM): the run bit is set.
- first-lead (ARM→MARK): the first leading edge arrives.
- trail (MARK→SPACE): a trailing edge arrives.
- relead (SPACE→MARK): a leading edge arrives.
- stop (any state→OFF): the run bit is cleared.
- overflow (MARK or SPACE→OFF): the count reaches all ones.

Top module: `pulse_meter`

## Requirements
- R1: After reset, the control, status, width and period registers read zero, and `irq_o` is low.
- R2: While the timer is armed and no leading edge has been seen, trailing edges capture nothing and set no flag.
- R3: A trailing edge stores floor(N/2) in the width register (address 2), where N is the number of clock cycles from the leading edge to the trailing edge.
- R4: A leading edge that follows a trailing edge stores floor(P/2) in the period register (address 3), where P is the number of cycles between the two leading edges. The count then restarts, so each period is measured on its own.
- R5: When control bit 1 is 1, a rising input is the leading edge. When bit 1 is 0, a falling input leads and the rising input is the trailing edge.
- R6: Control bit 2 selects what sets status bit 0. When bit 2 is 0, width capture sets it. When bit 2 is 1, only period capture sets it.
- R7: The period register reads zero until the first period after reset has been captured.
- R8: If the count reaches 2^CNT_W−1 cycles after a leading edge with no new leading edge, the timer stops. Control bit 0 is cleared, status bit 1 and status bit 0 are set, and no further captures happen.
- R9: Status bits 0 and 1 are sticky and cleared by writing 1 to them at address 1. A set event in the same cycle as the clear wins.
- R10: `irq_o` equals status bit 0 AND control bit 3.
- R11: Clearing control bit 0 stops the timer and returns it to waiting for a first leading edge. Width and period keep their values, and input edges have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wave_i | input | 1 | Asynchronous waveform to measure |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CNT_W | Combinational read data |
| irq_o | output | 1 | Interrupt output |

## Verification
The hardest case to reach is a write-one-to-clear landing on the same clock edge as a width capture. Only then does the priority of set over clear show at the ports. The bench reaches it from a known synchronizer latency. It drops the input on a falling clock edge, waits two more falling edges, and then holds the clear write across the next rising edge, which is the edge that captures the width. Overflow is reached by building the design with a 12-bit counter and holding the input still for more than 4095 cycles after a leading edge.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARM   = 2'd1,
        ST_MARK  = 2'd2,
        ST_SPACE = 2'd3
    } pm_state_e;

    typedef struct packed {
        logic irq_en;
        logic irq_on_period;
        logic rise_lead;
        logic run;
    } pm_ctrl_t;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_STATUS = 2'd1;
    localparam logic [1:0] ADDR_WIDTH  = 2'd2;
    localparam logic [1:0] ADDR_PERIOD = 2'd3;

    localparam int CTRL_BITS   = 4;
    localparam int STATUS_BITS = 2;

endpackage

// File: rtl/pm_edge_sync.sv
module pm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wave_i,
    input  logic rise_lead,
    output logic lead_o,
    output logic trail_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;
    logic              level;
    logic              rise;
    logic              fall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q[0] <= 1'b0;
        end else begin
            chain_q[0] <= wave_i;
        end
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q[g] <= 1'b0;
            end else begin
                chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign level = chain_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= level;
        end
    end

    always_comb begin
        rise    = level & ~last_q;
        fall    = ~level & last_q;
        lead_o  = rise_lead ? rise : fall;
        trail_o = rise_lead ? fall : rise;
    end

    p_edges_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_o && trail_o));

endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
    import pm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             lead,
    input  logic             trail,
    output logic             width_we,
    output logic             period_we,
    output logic             ovf_evt,
    output logic [CNT_W-1:0] cap_val
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    pm_state_e        state_q;
    pm_state_e        state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             at_max;

    assign at_max  = &cnt_q;
    assign cap_val = {1'b0, cnt_q[CNT_W-1:1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (run) state_d = ST_ARM;
            end
            ST_ARM: begin
                if (!run)      state_d = ST_OFF;
                else if (lead) state_d = ST_MARK;
            end
            ST_MARK: begin
                if (!run || at_max) state_d = ST_OFF;
                else if (trail)     state_d = ST_SPACE;
            end
            ST_SPACE: begin
                if (!run || at_max) state_d = ST_OFF;
                else if (lead)      state_d = ST_MARK;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        cnt_d     = '0;
        width_we  = 1'b0;
        period_we = 1'b0;
        ovf_evt   = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                cnt_d = '0;
            end
            ST_ARM: begin
                if (run && lead) cnt_d = CNT_ONE;
            end
            ST_MARK: begin
                if (run) begin
                    if (at_max) begin
                        ovf_evt = 1'b1;
                    end else begin
                        cnt_d    = cnt_q + CNT_ONE;
                        width_we = trail;
                    end
                end
            end
            ST_SPACE: begin
                if (run) begin
                    if (at_max) begin
                        ovf_evt = 1'b1;
                    end else if (lead) begin
                        cnt_d     = CNT_ONE;
                        period_we = 1'b1;
                    end else begin
                        cnt_d = cnt_q + CNT_ONE;
                    end
                end
            end
            default: cnt_d = '0;
        endcase
    end

    p_arm_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM) |-> (cnt_q == '0));

    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPACE && run && lead && !at_max) |=> (cnt_q == CNT_ONE));

    p_single_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(width_we && period_we));

    p_overflow_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> (state_q == ST_OFF));

endmodule

// File: rtl/pm_regs.sv
module pm_regs
    import pm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic             width_we,
    input  logic             period_we,
    input  logic             ovf_evt,
    input  logic [CNT_W-1:0] cap_val,
    output pm_ctrl_t         ctrl_o,
    output logic             irq_o
);

    pm_ctrl_t         ctrl_q;
    logic             irq_q;
    logic             ovf_q;
    logic [CNT_W-1:0] width_q;
    logic [CNT_W-1:0] period_q;
    logic             ctrl_wr;
    logic             clr_irq;
    logic             clr_ovf;
    logic             irq_set;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^wr_data[CNT_W-1:CTRL_BITS];

    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    assign clr_irq = wr_en && (wr_addr == ADDR_STATUS) && wr_data[0];
    assign clr_ovf = wr_en && (wr_addr == ADDR_STATUS) && wr_data[1];
    assign irq_set = ovf_evt
                   || (width_we  && !ctrl_q.irq_on_period)
                   || (period_we &&  ctrl_q.irq_on_period);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= pm_ctrl_t'(wr_data[CTRL_BITS-1:0]);
            if (ovf_evt) ctrl_q.run <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            irq_q <= (irq_q && !clr_irq) || irq_set;
            ovf_q <= (ovf_q && !clr_ovf) || ovf_evt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q  <= '0;
            period_q <= '0;
        end else begin
            if (width_we)  width_q  <= cap_val;
            if (period_we) period_q <= cap_val;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CTRL:   rd_data[CTRL_BITS-1:0]   = ctrl_q;
            ADDR_STATUS: rd_data[STATUS_BITS-1:0] = {ovf_q, irq_q};
            ADDR_WIDTH:  rd_data = width_q;
            ADDR_PERIOD: rd_data = period_q;
            default:     rd_data = '0;
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign irq_o  = irq_q && ctrl_q.irq_en;

    p_sticky_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !clr_irq) |=> irq_q);

    p_set_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> (ovf_q && irq_q));

    p_ovf_clears_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> !ctrl_q.run);

    p_width_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !width_we |=> $stable(width_q));

    p_period_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !period_we |=> $stable(period_q));

endmodule

// File: rtl/pulse_meter.sv
module pulse_meter
    import pm_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wave_i,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq_o
);

    pm_ctrl_t         ctrl;
    logic             lead;
    logic             trail;
    logic             width_we;
    logic             period_we;
    logic             ovf_evt;
    logic [CNT_W-1:0] cap_val;

    pm_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .wave_i    (wave_i),
        .rise_lead (ctrl.rise_lead),
        .lead_o    (lead),
        .trail_o   (trail)
    );

    pm_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctrl.run),
        .lead      (lead),
        .trail     (trail),
        .width_we  (width_we),
        .period_we (period_we),
        .ovf_evt   (ovf_evt),
        .cap_val   (cap_val)
    );

    pm_regs #(
        .CNT_W (CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .width_we  (width_we),
        .period_we (period_we),
        .ovf_evt   (ovf_evt),
        .cap_val   (cap_val),
        .ctrl_o    (ctrl),
        .irq_o     (irq_o)
    );

    p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ctrl.irq_en);

endmodule

// File: tb/pulse_meter_tb_top.sv
module pulse_meter_tb_top;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wave_i = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_addr = 2'd0;
    logic [W-1:0] rd_data;
    logic         irq_o;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        int           kind;
        logic [W-1:0] val;
        string        tag;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pulse_meter #(.CNT_W(W)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wave_i  (wave_i),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq_o   (irq_o)
    );

    // monitor: pops expected items and compares them with the port values
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t it;
                logic [W-1:0] act;
                it = exp_q.pop_front();
                if (it.kind < 4) rd_addr = it.kind[1:0];
                #1;
                act = (it.kind == 4) ? {{(W-1){1'b0}}, irq_o} : rd_data;
                n_checks++;
                if (act !== it.val) begin
                    n_fail++;
                    $display("FAIL %s: actual=%0d expected=%0d", it.tag, act, it.val);
                end
            end
        end
    end

    task automatic expect_item(input int kind, input int val, input string tag);
        exp_t it;
        it.kind = kind;
        it.val  = W'(val);
        it.tag  = tag;
        exp_q.push_back(it);
        wait (exp_q.size() == 0);
        #2;
    endtask

    task automatic reg_write(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_wave(input logic v, output int t);
        @(negedge clk);
        wave_i = v;
        t = cyc;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int ta, tb, tc, td, te, tf, tg, th, ti, tx;
        int w_keep, p_keep;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        expect_item(0, 0, "R1 ctrl after reset");
        expect_item(1, 0, "R1 status after reset");
        expect_item(2, 0, "R1 width after reset");
        expect_item(3, 0, "R1 period after reset");
        expect_item(4, 0, "R1 irq after reset");

        // input high before arming, so no edge is seen at enable
        set_wave(1'b1, tx);
        idle(6);
        reg_write(2'd0, 'b1011);
        set_wave(1'b0, tx);
        idle(8);
        expect_item(2, 0, "R2 trail while armed ignored (width)");
        expect_item(1, 0, "R2 trail while armed ignored (status)");

        set_wave(1'b1, ta);
        idle(10);
        set_wave(1'b0, tb);
        idle(8);
        expect_item(2, (tb - ta) / 2, "R3 width rising lead");
        expect_item(3, 0, "R7 period zero before first period");
        expect_item(1, 1, "R6 latch on width capture");
        expect_item(4, 1, "R10 irq with enable set");
        idle(5);
        set_wave(1'b1, tc);
        idle(6);
        expect_item(3, (tc - ta) / 2, "R4 first period");

        reg_write(2'd1, 3);
        expect_item(1, 0, "R9 write-one clears status");
        expect_item(4, 0, "R9 irq low after clear");

        reg_write(2'd0, 'b1111);
        set_wave(1'b0, td);
        idle(10);
        expect_item(2, (td - tc) / 2, "R3 width second pulse");
        expect_item(1, 0, "R6 no latch on width when period selected");
        set_wave(1'b1, te);
        idle(6);
        expect_item(3, (te - tc) / 2, "R4 period after restart");
        expect_item(1, 1, "R6 latch on period capture");

        reg_write(2'd0, 'b0111);
        expect_item(4, 0, "R10 irq masked");
        expect_item(1, 1, "R10 latch kept while masked");

        reg_write(2'd1, 1);
        reg_write(2'd0, 'b1011);
        // clear lands on the edge that captures the width
        set_wave(1'b0, tf);
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = 2'd1;
        wr_data = W'(1);
        @(negedge clk);
        wr_en = 1'b0;
        expect_item(1, 1, "R9 set wins over same-cycle clear");
        expect_item(2, (tf - te) / 2, "R3 width at collision");

        w_keep = (tf - te) / 2;
        p_keep = (te - tc) / 2;
        reg_write(2'd0, 'b1010);
        set_wave(1'b1, tx);
        idle(6);
        set_wave(1'b0, tx);
        idle(6);
        set_wave(1'b1, tx);
        idle(6);
        expect_item(2, w_keep, "R11 width kept when stopped");
        expect_item(3, p_keep, "R11 period kept when stopped");

        reg_write(2'd1, 3);
        reg_write(2'd0, 'b1001);
        set_wave(1'b0, tg);
        idle(12);
        set_wave(1'b1, th);
        idle(8);
        expect_item(2, (th - tg) / 2, "R5 width with falling lead");
        expect_item(1, 1, "R5 latch on width with falling lead");
        idle(3);
        set_wave(1'b0, ti);
        idle(6);
        expect_item(3, (ti - tg) / 2, "R5 period with falling lead");
        w_keep = (th - tg) / 2;
        p_keep = (ti - tg) / 2;

        reg_write(2'd1, 3);
        idle(4300);
        expect_item(0, 'b1000, "R8 run bit cleared on overflow");
        expect_item(1, 3, "R8 overflow and latch set");
        expect_item(4, 1, "R8 irq on overflow");
        set_wave(1'b1, tx);
        idle(6);
        set_wave(1'b0, tx);
        idle(6);
        expect_item(2, w_keep, "R8 no width capture after overflow");
        expect_item(3, p_keep, "R8 no period capture after overflow");

        reg_write(2'd1, 3);
        expect_item(1, 0, "R9 overflow flag cleared");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule